// File: doc/BRIEF.md
# Configurable Pixel Gain-Offset Corrector

This block corrects each 12-bit sample of an image converter stream in the digital domain. One shared 20-bit correction bus carries both a gain word and an offset word. A 3-bit split field decides where the boundary between the two words lies. The block subtracts the offset from the sample and clamps the result at zero. It then multiplies the difference by the gain, read as an unsigned fraction. Last, it can apply a power-of-two boost that saturates at full scale.

Each stage can be switched off separately. A clear split field removes the subtracter. A clear scale field removes both the multiplier and the boost. The result comes out of a register two clock cycles after its input, and a valid flag travels alongside it. A system feeds the block one sample per valid strobe and presents the matching correction bus and configuration in the same cycle.

Top module: `pgoc_top`

## Requirements
- R1: While reset is asserted and until the first valid sample comes through, `out_valid` is 0 and `out_data` is 0.
- R2: `out_valid` is high exactly two clock cycles after `in_valid` was high, and low otherwise.
- R3: With `cfg_split` = 000 the subtracter is bypassed, and the gain is the 12 bits `corr_bus[19:8]`.
- R4: When bit 0 is the lowest set bit of `cfg_split`, the gain is `corr_bus[19:10]` (10 bits) and the offset is `corr_bus[9:0]` (10 bits).
- R5: When bit 1 is the lowest set bit of `cfg_split`, the gain is `corr_bus[19:9]` (11 bits) and the offset is `corr_bus[8:0]` (9 bits).
- R6: When `cfg_split` = 100, the gain is `corr_bus[19:8]` (12 bits) and the offset is `corr_bus[7:0]` (8 bits).
- R7: When the offset is greater than or equal to the sample, the difference is 0.
- R8: With `cfg_scale` = 000 the multiplier and the boost are bypassed, and the output equals the difference.
- R9: With `cfg_scale` nonzero, the gain is left-aligned to 12 bits as G, with zeros filled in below. The product is floor(difference × G / 4096).
- R10: The lowest set bit of `cfg_scale` selects the boost: bit 0 gives ×2, bit 1 gives ×4 and bit 2 gives ×8. The boosted result saturates at 4095.
- R11: In a cycle where `out_valid` is low, `out_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| in_valid | input | 1 | The sample and the correction inputs are valid this cycle |
| in_sample | input | 12 | Raw sample |
| corr_bus | input | 20 | Shared correction bus, with the gain field at the top and the offset field at the bottom |
| cfg_scale | input | 3 | Boost select (×2, ×4, ×8); 000 bypasses the multiplier |
| cfg_split | input | 3 | Gain/offset split select; 000 bypasses the subtracter |
| out_valid | output | 1 | Corrected sample is valid |
| out_data | output | 12 | Corrected sample |

## Verification
The embedded properties check several things on every cycle:
- the two-cycle valid alignment;
- the idle state during reset;
- the zero clamp whenever the offset reaches the sample;
- the unchanged output on idle cycles;
- the exact pass-through when both fields are clear.

The bench has to show the rest with scenarios checked against a reference function:
- the arithmetic of each split mode;
- the lowest-bit priority in both fields;
- the fractional truncation;
- saturation at each boost level.

// File: rtl/pgoc_pkg.sv
`timescale 1ns/1ps
package pgoc_pkg;
  // Gain/offset distribution of the shared correction bus
  typedef enum logic [1:0] {
    SPLIT_NONE = 2'd0,  // full-width gain, subtracter bypassed
    SPLIT_G2   = 2'd1,  // gain short by two bits
    SPLIT_G1   = 2'd2,  // gain short by one bit
    SPLIT_G0   = 2'd3   // full-width gain, narrow offset
  } split_e;
endpackage

// File: rtl/pgoc_split.sv
`timescale 1ns/1ps
module pgoc_split #(
  parameter int BUS_W  = 20,
  parameter int GAIN_W = 12,
  localparam int OFF_W = BUS_W - GAIN_W + 2
) (
  input  pgoc_pkg::split_e    mode,
  input  logic [BUS_W-1:0]    bus,
  output logic [GAIN_W-1:0]   gain,
  output logic [OFF_W-1:0]    offset,
  output logic                sub_en
);
  import pgoc_pkg::*;

  always_comb begin
    gain   = bus[BUS_W-1 -: GAIN_W];
    offset = '0;
    sub_en = 1'b0;
    unique case (mode)
      SPLIT_G2: begin
        gain   = {bus[BUS_W-1 -: GAIN_W-2], 2'b00};
        offset = bus[OFF_W-1:0];
        sub_en = 1'b1;
      end
      SPLIT_G1: begin
        gain   = {bus[BUS_W-1 -: GAIN_W-1], 1'b0};
        offset = {1'b0, bus[OFF_W-2:0]};
        sub_en = 1'b1;
      end
      SPLIT_G0: begin
        offset = {2'b00, bus[OFF_W-3:0]};
        sub_en = 1'b1;
      end
      default: begin
        gain   = bus[BUS_W-1 -: GAIN_W];
        offset = '0;
        sub_en = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/pgoc_sub_stage.sv
`timescale 1ns/1ps
module pgoc_sub_stage #(
  parameter int DATA_W  = 12,
  parameter int GAIN_W  = 12,
  parameter int OFF_W   = 10,
  parameter int SHIFT_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [DATA_W-1:0]  in_sample,
  input  logic [OFF_W-1:0]   in_offset,
  input  logic               sub_en,
  input  logic [GAIN_W-1:0]  in_gain,
  input  logic [SHIFT_W-1:0] in_shift,
  output logic               s1_valid,
  output logic [DATA_W-1:0]  s1_data,
  output logic [GAIN_W-1:0]  s1_gain,
  output logic [SHIFT_W-1:0] s1_shift
);
  localparam int EXT_W = (DATA_W > OFF_W) ? DATA_W : OFF_W;

  logic [EXT_W-1:0]  samp_ext, off_ext;
  logic [DATA_W-1:0] diff_nxt;

  always_comb begin
    samp_ext = EXT_W'(in_sample);
    off_ext  = EXT_W'(in_offset);
    if (!sub_en)
      diff_nxt = in_sample;
    else if (samp_ext > off_ext)
      diff_nxt = DATA_W'(samp_ext - off_ext);
    else
      diff_nxt = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_data  <= '0;
      s1_gain  <= '0;
      s1_shift <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_data  <= diff_nxt;
        s1_gain  <= in_gain;
        s1_shift <= in_shift;
      end
    end
  end

  // R7: an offset that reaches the sample leaves a zero difference
  a_r7_clamp_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sub_en && (EXT_W'(in_offset) >= EXT_W'(in_sample))) |=> (s1_data == '0));
endmodule

// File: rtl/pgoc_gain_stage.sv
`timescale 1ns/1ps
module pgoc_gain_stage #(
  parameter int DATA_W     = 12,
  parameter int GAIN_W     = 12,
  parameter int SCALE_BITS = 3,
  parameter int SHIFT_W    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               s1_valid,
  input  logic [DATA_W-1:0]  s1_data,
  input  logic [GAIN_W-1:0]  s1_gain,
  input  logic [SHIFT_W-1:0] s1_shift,
  output logic               out_valid,
  output logic [DATA_W-1:0]  out_data
);
  localparam int PROD_W = DATA_W + GAIN_W;
  localparam int EXT_W  = DATA_W + SCALE_BITS;

  logic [PROD_W-1:0] prod;
  logic [DATA_W-1:0] frac;
  logic [EXT_W-1:0]  boosted;
  logic [DATA_W-1:0] res_nxt;

  always_comb begin
    prod    = PROD_W'(s1_data) * PROD_W'(s1_gain);
    frac    = prod[PROD_W-1 -: DATA_W];
    boosted = EXT_W'(frac) << s1_shift;
    if (s1_shift == '0)
      res_nxt = s1_data;
    else if (|boosted[EXT_W-1:DATA_W])
      res_nxt = '1;
    else
      res_nxt = boosted[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid)
        out_data <= res_nxt;
    end
  end

  // R11: output is held on cycles without a new result
  a_r11_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> $stable(out_data));
endmodule

// File: rtl/pgoc_top.sv
`timescale 1ns/1ps
module pgoc_top #(
  parameter int DATA_W     = 12,
  parameter int BUS_W      = 20,
  parameter int GAIN_W     = 12,
  parameter int SCALE_BITS = 3,
  parameter int SPLIT_BITS = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [DATA_W-1:0]     in_sample,
  input  logic [BUS_W-1:0]      corr_bus,
  input  logic [SCALE_BITS-1:0] cfg_scale,
  input  logic [SPLIT_BITS-1:0] cfg_split,
  output logic                  out_valid,
  output logic [DATA_W-1:0]     out_data
);
  import pgoc_pkg::*;

  localparam int OFF_W   = BUS_W - GAIN_W + 2;
  localparam int SHIFT_W = $clog2(SCALE_BITS + 1);

  // Reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  // Lowest set bit wins in both configuration fields
  logic [SHIFT_W-1:0] shift_sel;
  split_e             split_mode;
  always_comb begin
    shift_sel = '0;
    for (int i = SCALE_BITS - 1; i >= 0; i--)
      if (cfg_scale[i]) shift_sel = SHIFT_W'(i + 1);
  end
  always_comb begin
    split_mode = SPLIT_NONE;
    for (int i = SPLIT_BITS - 1; i >= 0; i--)
      if (cfg_split[i]) split_mode = split_e'(i + 1);
  end

  logic [GAIN_W-1:0]  gain_w;
  logic [OFF_W-1:0]   off_w;
  logic               sub_en;
  logic               s1_valid;
  logic [DATA_W-1:0]  s1_data;
  logic [GAIN_W-1:0]  s1_gain;
  logic [SHIFT_W-1:0] s1_shift;

  pgoc_split #(.BUS_W(BUS_W), .GAIN_W(GAIN_W)) u_split (
    .mode(split_mode), .bus(corr_bus), .gain(gain_w), .offset(off_w), .sub_en(sub_en)
  );

  pgoc_sub_stage #(.DATA_W(DATA_W), .GAIN_W(GAIN_W), .OFF_W(OFF_W), .SHIFT_W(SHIFT_W)) u_sub (
    .clk(clk), .rst_n(rst_int_n), .in_valid(in_valid), .in_sample(in_sample),
    .in_offset(off_w), .sub_en(sub_en), .in_gain(gain_w), .in_shift(shift_sel),
    .s1_valid(s1_valid), .s1_data(s1_data), .s1_gain(s1_gain), .s1_shift(s1_shift)
  );

  pgoc_gain_stage #(.DATA_W(DATA_W), .GAIN_W(GAIN_W), .SCALE_BITS(SCALE_BITS),
                    .SHIFT_W(SHIFT_W)) u_gain (
    .clk(clk), .rst_n(rst_int_n), .s1_valid(s1_valid), .s1_data(s1_data),
    .s1_gain(s1_gain), .s1_shift(s1_shift), .out_valid(out_valid), .out_data(out_data)
  );

  // Cycles since reset release, saturating, to gate the $past checks
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)        age_q <= 2'd0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R1: reset holds the output idle
  a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> !out_valid);

  // R2: valid emerges exactly two cycles later
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_int_n)
    (age_q >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

  // R8: both fields clear gives a pass-through of the sample
  a_r8_bypass: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((age_q >= 2'd2) && out_valid && $past(cfg_scale == '0 && cfg_split == '0, 2))
      |-> (out_data == $past(in_sample, 2)));
endmodule

// File: tb/test_pgoc_top.sv
`timescale 1ns/1ps
module test_pgoc_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [11:0] in_sample;
  logic [19:0] corr_bus;
  logic [2:0]  cfg_scale, cfg_split;
  logic        out_valid;
  logic [11:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pgoc_top i_pgoc_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .corr_bus(corr_bus), .cfg_scale(cfg_scale), .cfg_split(cfg_split),
    .out_valid(out_valid), .out_data(out_data)
  );

  // Reference model built from the requirements
  function automatic int model(int s, logic [19:0] b, logic [2:0] sc, logic [2:0] sp);
    int off, g, d, p, k;
    if (sp[0])      begin g = int'(b[19:10]) * 4; off = int'(b[9:0]); end // R4
    else if (sp[1]) begin g = int'(b[19:9]) * 2;  off = int'(b[8:0]); end // R5
    else if (sp[2]) begin g = int'(b[19:8]);      off = int'(b[7:0]); end // R6
    else            begin g = int'(b[19:8]);      off = 0;            end // R3
    d = s - off;
    if (d < 0) d = 0;                                                     // R7
    if (sc == 3'b000) return d;                                           // R8
    p = (d * g) >>> 12;                                                   // R9
    k = sc[0] ? 1 : (sc[1] ? 2 : 3);                                      // R10
    p = p << k;
    if (p > 4095) p = 4095;
    return p;
  endfunction

  function automatic string tag_of(logic [2:0] sc, logic [2:0] sp);
    string t;
    if (sp[0])      t = "R4";
    else if (sp[1]) t = "R5";
    else if (sp[2]) t = "R6";
    else            t = "R3";
    if (sc == 3'b000) t = {t, "/R8"};
    else              t = {t, "/R9/R10"};
    return t;
  endfunction

  bit          d1_v, d2_v;
  int          d1_d, d2_d;
  string       d1_t, d2_t;
  logic [11:0] last_out;

  task automatic fail(string req, int act, int exp);
    errors++;
    $display("FAIL %s: actual %0d expected %0d", req, act, exp);
  endtask

  task automatic check_out();
    checks++;
    if (out_valid !== d2_v) fail("R2 out_valid", int'(out_valid), int'(d2_v));
    checks++;
    if (d2_v) begin
      if (out_data !== 12'(d2_d)) fail(d2_t, int'(out_data), d2_d);
    end else begin
      if (out_data !== last_out) fail("R11 hold", int'(out_data), int'(last_out));
    end
    last_out = out_data;
  endtask

  task automatic step(bit v, int s, logic [19:0] b, logic [2:0] sc, logic [2:0] sp, string extra);
    @(negedge clk);
    check_out();
    d2_v = d1_v; d2_d = d1_d; d2_t = d1_t;
    in_valid  = v;
    in_sample = 12'(s);
    corr_bus  = b;
    cfg_scale = sc;
    cfg_split = sp;
    d1_v = v;
    d1_d = model(s, b, sc, sp);
    d1_t = {tag_of(sc, sp), extra};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    rst_n = 1'b0; in_valid = 1'b0; in_sample = '0; corr_bus = '0;
    cfg_scale = '0; cfg_split = '0;
    d1_v = 0; d2_v = 0; d1_d = 0; d2_d = 0; d1_t = ""; d2_t = "";
    last_out = '0;
    repeat (3) @(negedge clk);
    checks++;                                           // R1 during reset
    if (out_valid !== 1'b0 || out_data !== 12'd0) fail("R1 reset", int'(out_data), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;                                           // R1 after release
    if (out_valid !== 1'b0 || out_data !== 12'd0) fail("R1 idle", int'(out_data), 0);

    // Directed corners
    step(1, 1234, 20'hABCDE, 3'b000, 3'b000, " pass");           // R3, R8
    step(1, 100,  20'h003FF, 3'b000, 3'b001, " R7 clamp");       // offset 1023 > 100
    step(1, 500,  20'h001F4, 3'b000, 3'b001, " R7 equal");       // offset 500 == sample
    step(1, 3000, 20'h800FF, 3'b001, 3'b010, " x2");             // R5
    step(1, 4095, 20'hFFF00, 3'b100, 3'b100, " R10 sat x8");
    step(1, 2000, 20'h80010, 3'b110, 3'b011, " prio");           // R4 wins, R10 x4 wins
    step(0, 77,   20'h12345, 3'b001, 3'b001, "");                // R11 gap
    step(0, 88,   20'h54321, 3'b010, 3'b100, "");
    step(1, 4095, 20'hFFFFF, 3'b001, 3'b000, " R10 sat x2");
    step(1, 1,    20'h00100, 3'b100, 3'b000, " R9 trunc");
    step(1, 4095, 20'h00000, 3'b111, 3'b111, " zero gain");
    step(0, 0, '0, '0, '0, "");

    // Constrained random
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] sc, sp;
      sc = 3'($urandom);
      sp = 3'($urandom);
      if (($urandom % 4) == 0) sc = 3'b000;
      step(($urandom % 4) != 0, int'($urandom % 4096), 20'($urandom), sc, sp, " rnd");
    end
    step(0, 0, '0, '0, '0, "");
    step(0, 0, '0, '0, '0, "");
    step(0, 0, '0, '0, '0, "");
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule